// File: doc/BRIEF.md
# Core Module System Control Register Block

This block is a bank of 32-bit system control registers reached over a simple register bus: a byte address, a write enable with write data, and a read enable whose data appears on the read port one clock later. It holds a constant identity word and a constant status word, main and auxiliary clock-generator settings guarded by an unlock key, a control register, SDRAM configuration and initialisation words, and two flag words that have separate set and clear addresses.

A small interrupt group combines one software-driven interrupt level with two enable masks. Its results drive a registered IRQ output and a registered FIQ output. The control register drives a status LED output and a boot-overlay output, and a write with its reset bit set gives a one-cycle system reset request. A read-only window exposes a 32-entry memory description table. The installed memory size is a parameter, and it sets the SDRAM size code and the last table entry. An access to an address that the block does not decode gives a one-cycle error strobe.

Top module: `cm_sysctl`

## Requirements
- R1: After reset, word index 0 reads 0x411A3001, index 4 reads 0x00100000, index 2 reads 0x01000048, index 7 reads 0x0007FEFF, index 9 reads 0x00000112, index 3 reads 0, and index 8 reads 0x00011122 ORed with the size code (0x10 for at least 256 MB, 0x0C for at least 128 MB, 0x08 for at least 64 MB, 0x04 for at least 32 MB, otherwise 0). The word index is the byte address divided by four.
- R2: A write to index 5 keeps only bits 15:0. While the kept value is 0xA05F, index 5 reads 0x0001A05F. Otherwise it reads the kept value, zero-extended.
- R3: Writes to index 2 and index 7 change the register only while index 5 holds 0xA05F. At all other times they are ignored.
- R4: The control register (index 3) keeps only bit 0 (the LED, also driven on `led_o`) and bit 2. Writing bit 3 as 1 raises `sys_rst_req_o` for exactly the cycle after the write edge. Bit 3 always reads 0.
- R5: `boot_overlay_o` is the inverse of control bit 2, so the boot overlay is present after reset.
- R6: A write to index 12 ORs its data into the flags word, and a write to index 13 clears the bits that are set in its data. Index 14 and index 15 do the same for the non-volatile flags word. The current values read back at index 12 and index 14.
- R7: Index 8 and index 9 store and read back all 32 bits.
- R8: Interrupt level bit 0 is set by a write to index 20 with data bit 0 set, and cleared the same way through index 21. Index 20 reads the level. Index 18 ORs data into the IRQ enable mask, index 19 clears mask bits, and index 18 reads the mask back. Index 17 reads the raw level and index 16 reads the level ANDed with the mask. Indices 24 to 27 do the same for the FIQ mask: 24 reads the status, 25 the raw level, 26 sets and reads the mask, and 27 clears it.
- R9: `irq_o` (and likewise `fiq_o`) is registered. In each cycle it equals the OR of the level ANDed with the IRQ (FIQ) mask as they stood after the previous clock edge.
- R10: A read at byte address 0x100 + 4k, for k from 0 to 31, returns table entry k zero-extended. Entry 0 is 0x80, entry 3 is 0x0B, and entry 31 is the size byte (64, 32, 16, 4 or 2 for the same size steps as R1). Byte addresses 0x180 to 0x1FF read 0. Writes to 0x100 to 0x1FF are ignored and raise no error.
- R11: Indices 32 to 35 read 0 and ignore writes. Index 1 reads 0. Neither raises an error.
- R12: A read or write at any other index, or at a byte address that is not a multiple of four, changes no state and reads 0. It also raises `err_o` for exactly the cycle after the access edge.
- R13: `bus_rdata` loads at the edge where `bus_re` is sampled high, and holds its value while `bus_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 10 | Byte address of the access |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_re` |
| irq_o | output | 1 | Registered IRQ request |
| fiq_o | output | 1 | Registered FIQ request |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| boot_overlay_o | output | 1 | High while the boot overlay is at address zero |
| led_o | output | 1 | LED control bit |
| err_o | output | 1 | One-cycle strobe after an undecoded access |

## Verification
Read data, the error strobe, the reset request, the LED and the overlay output all settle at the single edge that samples the access, so the bench reads each of them at the falling edge that follows. The interrupt outputs go through a second register stage and change one cycle after the level or mask does. The bench therefore checks them once at the first falling edge, where they must still show the old value, and again one cycle later, where they must show the new value. The pulse outputs are checked again a cycle after the access, where they must have returned low.

// File: rtl/cm_sysctl_pkg.sv
package cm_sysctl_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 10;
    localparam int IDX_W  = ADDR_W - 2;
    localparam int TBL_AW = 5;

    localparam logic [DATA_W-1:0] ID_WORD     = 32'h411A_3001;
    localparam logic [DATA_W-1:0] STAT_WORD   = 32'h0010_0000;
    localparam logic [DATA_W-1:0] OSC_INIT    = 32'h0100_0048;
    localparam logic [DATA_W-1:0] AUX_INIT    = 32'h0007_FEFF;
    localparam logic [DATA_W-1:0] MEMINIT_RST = 32'h0000_0112;
    localparam logic [DATA_W-1:0] SDRAM_BASE  = 32'h0001_1122;
    localparam logic [15:0]       UNLOCK_KEY  = 16'hA05F;
    localparam logic [DATA_W-1:0] LOCK_OPEN_RD = 32'h0001_A05F;

    typedef enum logic [IDX_W-1:0] {
        IX_ID       = 8'd0,
        IX_PROC     = 8'd1,
        IX_OSC      = 8'd2,
        IX_CTRL     = 8'd3,
        IX_STAT     = 8'd4,
        IX_LOCK     = 8'd5,
        IX_AUX      = 8'd7,
        IX_SDRAM    = 8'd8,
        IX_MEMINIT  = 8'd9,
        IX_FLG_SET  = 8'd12,
        IX_FLG_CLR  = 8'd13,
        IX_NVF_SET  = 8'd14,
        IX_NVF_CLR  = 8'd15,
        IX_IRQ_STAT = 8'd16,
        IX_IRQ_RAW  = 8'd17,
        IX_IRQ_ENS  = 8'd18,
        IX_IRQ_ENC  = 8'd19,
        IX_SW_SET   = 8'd20,
        IX_SW_CLR   = 8'd21,
        IX_FIQ_STAT = 8'd24,
        IX_FIQ_RAW  = 8'd25,
        IX_FIQ_ENS  = 8'd26,
        IX_FIQ_ENC  = 8'd27
    } reg_idx_e;

    typedef struct packed {
        logic osc;
        logic ctrl;
        logic lock;
        logic aux;
        logic sdram;
        logic meminit;
        logic flg_set;
        logic flg_clr;
        logic nvf_set;
        logic nvf_clr;
        logic irq_ens;
        logic irq_enc;
        logic fiq_ens;
        logic fiq_enc;
        logic sw_set;
        logic sw_clr;
    } wr_sel_t;

    function automatic logic [7:0] size_code(input int mb);
        if (mb >= 256)     return 8'h10;
        else if (mb >= 128) return 8'h0C;
        else if (mb >= 64)  return 8'h08;
        else if (mb >= 32)  return 8'h04;
        else                return 8'h00;
    endfunction

    function automatic logic [7:0] size_byte(input int mb);
        if (mb >= 256)     return 8'd64;
        else if (mb >= 128) return 8'd32;
        else if (mb >= 64)  return 8'd16;
        else if (mb >= 32)  return 8'd4;
        else                return 8'd2;
    endfunction

    function automatic logic [7:0] tbl_entry(input logic [TBL_AW-1:0] k, input int mb);
        case (k)
            5'd0:  return 8'd128;
            5'd1:  return 8'd8;
            5'd2:  return 8'd4;
            5'd3:  return 8'd11;
            5'd4:  return 8'd9;
            5'd5:  return 8'd1;
            5'd6:  return 8'd64;
            5'd8:  return 8'd2;
            5'd9:  return 8'hA0;
            5'd10: return 8'hA0;
            5'd13: return 8'd8;
            5'd15: return 8'd1;
            5'd16: return 8'h0E;
            5'd17: return 8'd4;
            5'd18: return 8'h1C;
            5'd19: return 8'd1;
            5'd20: return 8'd2;
            5'd21: return 8'h20;
            5'd22: return 8'hC0;
            5'd27: return 8'h30;
            5'd28: return 8'h28;
            5'd29: return 8'h30;
            5'd30: return 8'h28;
            5'd31: return size_byte(mb);
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cm_decode.sv
module cm_decode
    import cm_sysctl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              re,
    output wr_sel_t           wsel,
    output logic              rd_hit,
    output logic              err
);
    logic [IDX_W-1:0] idx;
    logic             aligned;
    logic             in_window;
    logic             in_volt;
    logic             wr_known;
    logic             rd_known;

    assign idx       = addr[ADDR_W-1:2];
    assign aligned   = (addr[1:0] == 2'b00);
    assign in_window = (idx[IDX_W-1:IDX_W-2] == 2'b01);
    assign in_volt   = (idx[IDX_W-1:2] == 6'b001000);

    always_comb begin
        wsel     = '0;
        wr_known = in_window | in_volt;
        case (idx)
            IX_OSC:     begin wsel.osc     = 1'b1; wr_known = 1'b1; end
            IX_CTRL:    begin wsel.ctrl    = 1'b1; wr_known = 1'b1; end
            IX_LOCK:    begin wsel.lock    = 1'b1; wr_known = 1'b1; end
            IX_AUX:     begin wsel.aux     = 1'b1; wr_known = 1'b1; end
            IX_SDRAM:   begin wsel.sdram   = 1'b1; wr_known = 1'b1; end
            IX_MEMINIT: begin wsel.meminit = 1'b1; wr_known = 1'b1; end
            IX_FLG_SET: begin wsel.flg_set = 1'b1; wr_known = 1'b1; end
            IX_FLG_CLR: begin wsel.flg_clr = 1'b1; wr_known = 1'b1; end
            IX_NVF_SET: begin wsel.nvf_set = 1'b1; wr_known = 1'b1; end
            IX_NVF_CLR: begin wsel.nvf_clr = 1'b1; wr_known = 1'b1; end
            IX_IRQ_ENS: begin wsel.irq_ens = 1'b1; wr_known = 1'b1; end
            IX_IRQ_ENC: begin wsel.irq_enc = 1'b1; wr_known = 1'b1; end
            IX_FIQ_ENS: begin wsel.fiq_ens = 1'b1; wr_known = 1'b1; end
            IX_FIQ_ENC: begin wsel.fiq_enc = 1'b1; wr_known = 1'b1; end
            IX_SW_SET:  begin wsel.sw_set  = 1'b1; wr_known = 1'b1; end
            IX_SW_CLR:  begin wsel.sw_clr  = 1'b1; wr_known = 1'b1; end
            default: ;
        endcase
        if (!(we && aligned)) wsel = '0;
    end

    always_comb begin
        case (idx)
            IX_ID, IX_PROC, IX_OSC, IX_CTRL, IX_STAT, IX_LOCK, IX_AUX,
            IX_SDRAM, IX_MEMINIT, IX_FLG_SET, IX_NVF_SET,
            IX_IRQ_STAT, IX_IRQ_RAW, IX_IRQ_ENS, IX_SW_SET,
            IX_FIQ_STAT, IX_FIQ_RAW, IX_FIQ_ENS: rd_known = 1'b1;
            default: rd_known = in_window | in_volt;
        endcase
    end

    assign rd_hit = rd_known & aligned;
    assign err    = (we & ~(wr_known & aligned)) | (re & ~rd_hit);

endmodule

// File: rtl/cm_int_path.sv
module cm_int_path #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] level,
    output logic [W-1:0] en_o,
    output logic         req_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_o  <= '0;
            req_o <= 1'b0;
        end else begin
            if (set_we)      en_o <= en_o | wdata;
            else if (clr_we) en_o <= en_o & ~wdata;
            req_o <= |(level & en_o);
        end
    end
endmodule

// File: rtl/cm_spd_rom.sv
module cm_spd_rom
    import cm_sysctl_pkg::*;
#(
    parameter int MEM_MB = 128
) (
    input  logic [TBL_AW-1:0] k,
    output logic [7:0]        val
);
    assign val = tbl_entry(k, MEM_MB);
endmodule

// File: rtl/cm_sysctl.sv
module cm_sysctl
    import cm_sysctl_pkg::*;
#(
    parameter int MEM_MB = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              fiq_o,
    output logic              sys_rst_req_o,
    output logic              boot_overlay_o,
    output logic              led_o,
    output logic              err_o
);
    localparam logic [DATA_W-1:0] SDRAM_RST = SDRAM_BASE | {24'b0, size_code(MEM_MB)};
    localparam int NPATH = 2;

    wr_sel_t           wsel;
    logic              rd_hit;
    logic              err_w;
    logic [IDX_W-1:0]  idx;
    logic [7:0]        tbl_val;
    logic [DATA_W-1:0] rd_val;

    logic [DATA_W-1:0] osc_q, aux_q, sdram_q, meminit_q, flags_q, nvflags_q;
    logic [15:0]       lock_q;
    logic              led_q, remap_q, sw_q, rst_pulse_q, err_q;
    logic              key_ok;
    logic [DATA_W-1:0] level_vec;

    logic [NPATH-1:0]  path_set, path_clr, path_req;
    logic [DATA_W-1:0] path_en [NPATH];
    logic [DATA_W-1:0] irq_en_w, fiq_en_w;

    assign idx       = bus_addr[ADDR_W-1:2];
    assign key_ok    = (lock_q == UNLOCK_KEY);
    assign level_vec = {{(DATA_W-1){1'b0}}, sw_q};

    cm_decode u_decode (
        .addr   (bus_addr),
        .we     (bus_we),
        .re     (bus_re),
        .wsel   (wsel),
        .rd_hit (rd_hit),
        .err    (err_w)
    );

    cm_spd_rom #(.MEM_MB(MEM_MB)) u_tbl (
        .k   (idx[TBL_AW-1:0]),
        .val (tbl_val)
    );

    assign path_set = {wsel.fiq_ens, wsel.irq_ens};
    assign path_clr = {wsel.fiq_enc, wsel.irq_enc};

    for (genvar g = 0; g < NPATH; g++) begin : g_path
        cm_int_path #(.W(DATA_W)) u_path (
            .clk    (clk),
            .rst    (rst),
            .set_we (path_set[g]),
            .clr_we (path_clr[g]),
            .wdata  (bus_wdata),
            .level  (level_vec),
            .en_o   (path_en[g]),
            .req_o  (path_req[g])
        );
    end

    assign irq_en_w = path_en[0];
    assign fiq_en_w = path_en[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            osc_q       <= OSC_INIT;
            aux_q       <= AUX_INIT;
            sdram_q     <= SDRAM_RST;
            meminit_q   <= MEMINIT_RST;
            flags_q     <= '0;
            nvflags_q   <= '0;
            lock_q      <= '0;
            led_q       <= 1'b0;
            remap_q     <= 1'b0;
            sw_q        <= 1'b0;
            rst_pulse_q <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            if (wsel.osc && key_ok) osc_q <= bus_wdata;
            if (wsel.aux && key_ok) aux_q <= bus_wdata;
            if (wsel.lock)    lock_q    <= bus_wdata[15:0];
            if (wsel.sdram)   sdram_q   <= bus_wdata;
            if (wsel.meminit) meminit_q <= bus_wdata;
            if (wsel.flg_set) flags_q   <= flags_q | bus_wdata;
            if (wsel.flg_clr) flags_q   <= flags_q & ~bus_wdata;
            if (wsel.nvf_set) nvflags_q <= nvflags_q | bus_wdata;
            if (wsel.nvf_clr) nvflags_q <= nvflags_q & ~bus_wdata;
            if (wsel.ctrl) begin
                led_q   <= bus_wdata[0];
                remap_q <= bus_wdata[2];
            end
            if (wsel.sw_set && bus_wdata[0]) sw_q <= 1'b1;
            if (wsel.sw_clr && bus_wdata[0]) sw_q <= 1'b0;
            rst_pulse_q <= wsel.ctrl & bus_wdata[3];
            err_q       <= err_w;
        end
    end

    always_comb begin
        case (idx)
            IX_ID:       rd_val = ID_WORD;
            IX_OSC:      rd_val = osc_q;
            IX_CTRL:     rd_val = {{(DATA_W-3){1'b0}}, remap_q, 1'b0, led_q};
            IX_STAT:     rd_val = STAT_WORD;
            IX_LOCK:     rd_val = key_ok ? LOCK_OPEN_RD : {16'b0, lock_q};
            IX_AUX:      rd_val = aux_q;
            IX_SDRAM:    rd_val = sdram_q;
            IX_MEMINIT:  rd_val = meminit_q;
            IX_FLG_SET:  rd_val = flags_q;
            IX_NVF_SET:  rd_val = nvflags_q;
            IX_IRQ_STAT: rd_val = level_vec & irq_en_w;
            IX_IRQ_RAW:  rd_val = level_vec;
            IX_IRQ_ENS:  rd_val = irq_en_w;
            IX_SW_SET:   rd_val = level_vec;
            IX_FIQ_STAT: rd_val = level_vec & fiq_en_w;
            IX_FIQ_RAW:  rd_val = level_vec;
            IX_FIQ_ENS:  rd_val = fiq_en_w;
            default:     rd_val = (idx[IDX_W-1:IDX_W-2] == 2'b01 && !idx[TBL_AW])
                                  ? {24'b0, tbl_val} : '0;
        endcase
        if (!rd_hit) rd_val = '0;
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_val;
    end

    assign irq_o          = path_req[0];
    assign fiq_o          = path_req[1];
    assign sys_rst_req_o  = rst_pulse_q;
    assign boot_overlay_o = ~remap_q;
    assign led_o          = led_q;
    assign err_o          = err_q;

endmodule

// File: rtl/cm_sysctl_chk.sv
module cm_sysctl_chk
    import cm_sysctl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_re,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_o,
    input logic              fiq_o,
    input logic              sys_rst_req_o,
    input logic              boot_overlay_o,
    input logic              err_o,
    input logic              key_ok,
    input logic [DATA_W-1:0] osc_q,
    input logic [DATA_W-1:0] aux_q,
    input logic [DATA_W-1:0] level_vec,
    input logic [DATA_W-1:0] irq_en,
    input logic [DATA_W-1:0] fiq_en
);
    logic ctrl_wr;
    assign ctrl_wr = bus_we && (bus_addr == 10'(4 * 3));

    assert_osc_locked_R3: assert property (@(posedge clk) disable iff (rst)
        !key_ok |=> ($stable(osc_q) && $stable(aux_q)));

    assert_rst_pulse_src_R4: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req_o |-> $past(ctrl_wr && bus_wdata[3]));

    assert_overlay_drop_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(boot_overlay_o) |-> $past(ctrl_wr && bus_wdata[2]));

    assert_irq_reg_R9: assert property (@(posedge clk) disable iff (rst)
        irq_o == ($past(level_vec & irq_en) != '0));

    assert_fiq_reg_R9: assert property (@(posedge clk) disable iff (rst)
        fiq_o == ($past(level_vec & fiq_en) != '0));

    assert_err_src_R12: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $past(bus_we || bus_re));

    assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> $stable(bus_rdata));

endmodule

bind cm_sysctl cm_sysctl_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .bus_addr       (bus_addr),
    .bus_we         (bus_we),
    .bus_wdata      (bus_wdata),
    .bus_re         (bus_re),
    .bus_rdata      (bus_rdata),
    .irq_o          (irq_o),
    .fiq_o          (fiq_o),
    .sys_rst_req_o  (sys_rst_req_o),
    .boot_overlay_o (boot_overlay_o),
    .err_o          (err_o),
    .key_ok         (key_ok),
    .osc_q          (osc_q),
    .aux_q          (aux_q),
    .level_vec      (level_vec),
    .irq_en         (irq_en_w),
    .fiq_en         (fiq_en_w)
);

// File: tb/tb_cm_sysctl.sv
`timescale 1ns/1ps
module tb_cm_sysctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o, sys_rst_req_o, boot_overlay_o, led_o, err_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cm_sysctl #(.MEM_MB(128)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o), .sys_rst_req_o(sys_rst_req_o),
        .boot_overlay_o(boot_overlay_o), .led_o(led_o), .err_o(err_o)
    );

    function automatic logic [31:0] exp_sdram_rst(input int mb);
        logic [31:0] c;
        c = (mb >= 256) ? 32'h10 : (mb >= 128) ? 32'h0C : (mb >= 64) ? 32'h08 :
            (mb >= 32) ? 32'h04 : 32'h0;
        return 32'h0001_1122 | c;
    endfunction

    function automatic logic [31:0] exp_size_byte(input int mb);
        return (mb >= 256) ? 32'd64 : (mb >= 128) ? 32'd32 : (mb >= 64) ? 32'd16 :
               (mb >= 32) ? 32'd4 : 32'd2;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr_at(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        wr_at(10'(idx * 4), d);
    endtask

    task automatic rd_at(input logic [9:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        v = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input int idx, input logic [31:0] exp);
        logic [31:0] v;
        rd_at(10'(idx * 4), v);
        chk(req, v, exp);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, fl, nvf, ien, fen, d;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 / R5 reset state
        chk("R5 overlay at reset", 32'(boot_overlay_o), 32'd1);
        chk("R9 irq at reset", 32'(irq_o), 0);
        chk("R4 led at reset", 32'(led_o), 0);
        rd_chk("R1 id", 0, 32'h411A_3001);
        rd_chk("R1 status", 4, 32'h0010_0000);
        rd_chk("R1 osc", 2, 32'h0100_0048);
        rd_chk("R1 aux osc", 7, 32'h0007_FEFF);
        rd_chk("R1 init", 9, 32'h0000_0112);
        rd_chk("R1 sdram", 8, exp_sdram_rst(128));
        rd_chk("R1 ctrl", 3, 0);

        // R12 undecoded accesses
        rd_at(10'(6 * 4), v);
        chk("R12 read value", v, 0);
        chk("R12 err after read", 32'(err_o), 1);
        @(negedge clk);
        chk("R12 err one cycle", 32'(err_o), 0);
        wr(0, 32'hFFFF_FFFF);
        chk("R12 err on read-only write", 32'(err_o), 1);
        rd_chk("R12 id unchanged", 0, 32'h411A_3001);
        wr_at(10'h00A, 32'h1234_5678);
        chk("R12 err misaligned", 32'(err_o), 1);
        rd_chk("R12 osc unchanged", 2, 32'h0100_0048);

        // R2 / R3 lock behaviour
        wr(2, 32'hDEAD_BEEF);
        chk("R3 no err on locked write", 32'(err_o), 0);
        rd_chk("R3 osc locked", 2, 32'h0100_0048);
        wr(5, 32'h1234_A05F);
        rd_chk("R2 key read", 5, 32'h0001_A05F);
        wr(2, 32'hDEAD_BEEF);
        wr(7, 32'h0BAD_CAFE);
        rd_chk("R3 osc unlocked", 2, 32'hDEAD_BEEF);
        rd_chk("R3 aux unlocked", 7, 32'h0BAD_CAFE);
        wr(5, 32'hFFFF_1234);
        rd_chk("R2 low half kept", 5, 32'h0000_1234);
        wr(7, 32'h1111_1111);
        rd_chk("R3 aux locked again", 7, 32'h0BAD_CAFE);

        // R4 / R5 control register
        wr(3, 32'hFFFF_FFFF);
        chk("R4 reset pulse", 32'(sys_rst_req_o), 1);
        chk("R4 led on", 32'(led_o), 1);
        chk("R5 overlay removed", 32'(boot_overlay_o), 0);
        @(negedge clk);
        chk("R4 pulse one cycle", 32'(sys_rst_req_o), 0);
        rd_chk("R4 ctrl kept bits", 3, 32'h5);
        wr(3, 32'h0000_0008);
        chk("R4 reset pulse again", 32'(sys_rst_req_o), 1);
        chk("R5 overlay back", 32'(boot_overlay_o), 1);
        rd_chk("R4 bit3 reads zero", 3, 0);

        // R6 flags, random set/clear
        fl = '0; nvf = '0;
        for (int i = 0; i < 24; i++) begin
            d = $urandom;
            case ($urandom % 4)
                0: begin wr(12, d); fl  = fl | d;   end
                1: begin wr(13, d); fl  = fl & ~d;  end
                2: begin wr(14, d); nvf = nvf | d;  end
                default: begin wr(15, d); nvf = nvf & ~d; end
            endcase
            if (i % 4 == 3) begin
                rd_chk("R6 flags", 12, fl);
                rd_chk("R6 nv flags", 14, nvf);
            end
        end

        // R7 sdram / init
        for (int i = 0; i < 4; i++) begin
            d = $urandom; wr(8, d); rd_chk("R7 sdram", 8, d);
            d = $urandom; wr(9, d); rd_chk("R7 init", 9, d);
        end

        // R8 / R9 interrupt group
        wr(18, 32'h1);
        rd_chk("R8 irq mask", 18, 32'h1);
        wr(20, 32'h1);
        chk("R9 irq not yet", 32'(irq_o), 0);
        @(negedge clk);
        chk("R9 irq raised", 32'(irq_o), 1);
        chk("R9 fiq off", 32'(fiq_o), 0);
        rd_chk("R8 raw", 17, 32'h1);
        rd_chk("R8 irq status", 16, 32'h1);
        rd_chk("R8 soft read", 20, 32'h1);
        rd_chk("R8 fiq status masked", 24, 0);
        wr(26, 32'h3);
        rd_chk("R8 fiq mask", 26, 32'h3);
        rd_chk("R8 fiq status", 24, 32'h1);
        chk("R9 fiq raised", 32'(fiq_o), 1);
        wr(19, 32'h1);
        rd_chk("R8 irq mask cleared", 18, 0);
        chk("R9 irq dropped", 32'(irq_o), 0);
        wr(21, 32'h0);
        rd_chk("R8 clear needs bit0", 25, 32'h1);
        wr(21, 32'h1);
        rd_chk("R8 raw cleared", 25, 0);
        chk("R9 fiq dropped", 32'(fiq_o), 0);
        ien = '0; fen = 32'h3;
        for (int i = 0; i < 12; i++) begin
            d = $urandom;
            case ($urandom % 4)
                0: begin wr(18, d); ien = ien | d;  end
                1: begin wr(19, d); ien = ien & ~d; end
                2: begin wr(26, d); fen = fen | d;  end
                default: begin wr(27, d); fen = fen & ~d; end
            endcase
        end
        rd_chk("R8 irq mask random", 18, ien);
        rd_chk("R8 fiq mask random", 26, fen);

        // R10 table window
        rd_at(10'h100, v); chk("R10 entry 0", v, 32'h80);
        rd_at(10'h10C, v); chk("R10 entry 3", v, 32'h0B);
        rd_at(10'h17C, v); chk("R10 size entry", v, exp_size_byte(128));
        rd_at(10'h180, v); chk("R10 upper zero", v, 0);
        rd_at(10'h1FC, v); chk("R10 last zero", v, 0);
        wr_at(10'h100, 32'hFF);
        chk("R10 write no err", 32'(err_o), 0);
        rd_at(10'h100, v); chk("R10 write ignored", v, 32'h80);

        // R11 voltage and processor words
        for (int k = 32; k < 36; k++) begin
            wr(k, 32'hFFFF_FFFF);
            chk("R11 write no err", 32'(err_o), 0);
            rd_chk("R11 reads zero", k, 0);
        end
        rd_chk("R11 proc reads zero", 1, 0);

        // R13 read data holds
        rd_chk("R13 load", 0, 32'h411A_3001);
        @(negedge clk); bus_addr = 10'h008;
        @(negedge clk); @(negedge clk);
        chk("R13 hold", bus_rdata, 32'h411A_3001);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule